// File: doc/BRIEF.md
# L2 Way-Code Store for a Write-Through L1

This block keeps, for every line of a set-associative write-through L1 data cache, the number of the L2 way that holds that line's copy. It is addressed with the same set index the CPU presents to the L1 data array, together with the L1 way, so it works in step with that array. The L1 data array, the L2 arrays and the replacement policy are outside this block.

When a line is brought in from L2, the cache controller raises the update strobe together with the write strobe. The code from the L2 way register is then stored, and the entry is marked valid. When the L1 performs a store, the write strobe is raised without the update strobe. The stored code comes back one cycle later, so the L2 write can enable a single way. On L1 loads the write strobe stays low, and the array is neither read nor written. An invalidate input withdraws an entry when either copy of the line is evicted. A lookup of an entry that is not valid reports that no code is available.

The entry count is the L1 data size divided by the L1 line size. The code width is log2 of the L2 way count, which is two bits for the default four-way L2.

Top module: `wt_way_tag_array`

## Requirements
- R1: Each (L1 way, set index) pair selects its own entry at address {l1way_i, idx_i}. Writing one entry leaves every other entry, including the other L1 ways of the same set, unchanged.
- R2: When upd_i=1 and wr_i=1 at a clock edge, code_i is stored at the addressed entry and that entry becomes valid.
- R3: When upd_i=0 and wr_i=1 at a clock edge and the addressed entry is valid, then from the next edge code_o equals the stored code and valid_o=1.
- R4: A lookup (upd_i=0, wr_i=1) of an entry that is not valid gives valid_o=0 after the next edge.
- R5: When wr_i=0 the array is not accessed. After the next edge valid_o=0 and code_o keeps its previous value. No entry changes, even when upd_i=1.
- R6: Reset (rst=1, synchronous, active high) makes every entry not valid and sets valid_o=0 and code_o=0.
- R7: When inval_i=1 and no fill is requested, the addressed entry becomes not valid. A lookup in the same cycle still reports the state the entry had before that edge.
- R8: A fill and an invalidate in the same cycle leave the entry valid, holding the new code.
- R9: L2 ways are coded in CODE_W=log2(L2_WAYS) bits (00, 01, 10, 11 for four ways). Every code value is returned exactly as stored.
- R10: A fill takes priority over a lookup. When upd_i=1 and wr_i=1, no read takes place: valid_o=0 after the edge and code_o holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_i | input | SET_W | L1 set index, shared with the L1 data array |
| l1way_i | input | L1W_W | L1 way that holds (or receives) the line |
| upd_i | input | 1 | Fill request from the cache controller |
| wr_i | input | 1 | Access strobe, high on L1 stores and fills |
| inval_i | input | 1 | Clear the valid bit of the addressed entry |
| code_i | input | CODE_W | L2 way code from the L2 way register |
| code_o | output | CODE_W | Registered L2 way code from the last lookup |
| valid_o | output | 1 | High for one cycle after a lookup of a valid entry |

## Verification
A corrupted code bit or a lost valid bit cannot be seen until the affected entry is next looked up. At that lookup it shows one cycle later, as a wrong code_o or a wrong valid_o. The bench therefore interleaves fills, invalidates and lookups on a small set of addresses, so every entry is read back soon after each change. A control decode fault shows in the cycle after the faulty access, as a read response or a code_o change where none is allowed.

// File: rtl/wt_pkg.sv
package wt_pkg;

  typedef enum logic [1:0] {
    WT_IDLE   = 2'd0,
    WT_FILL   = 2'd1,
    WT_LOOKUP = 2'd2
  } wt_op_e;

  typedef struct packed {
    logic ram_we;
    logic ram_re;
    logic vb_set;
    logic vb_clr;
  } wt_ctl_t;

  function automatic int code_width(input int ways);
    return (ways > 1) ? $clog2(ways) : 1;
  endfunction

endpackage

// File: rtl/wt_ctrl.sv
module wt_ctrl
  import wt_pkg::*;
(
  input  logic    upd_i,
  input  logic    wr_i,
  input  logic    inval_i,
  output wt_op_e  op_o,
  output wt_ctl_t ctl_o
);

  always_comb begin
    if (!wr_i)      op_o = WT_IDLE;
    else if (upd_i) op_o = WT_FILL;
    else            op_o = WT_LOOKUP;
  end

  always_comb begin
    ctl_o.ram_we = (op_o == WT_FILL);
    ctl_o.ram_re = (op_o == WT_LOOKUP);
    ctl_o.vb_set = (op_o == WT_FILL);
    ctl_o.vb_clr = inval_i && (op_o != WT_FILL);
  end

endmodule

// File: rtl/wt_code_ram.sv
module wt_code_ram #(
  parameter int DEPTH = 128,
  parameter int AW    = 7,
  parameter int DW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[addr];
  end

endmodule

// File: rtl/wt_valid_bits.sv
module wt_valid_bits #(
  parameter int DEPTH = 128,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set,
  input  logic          clr,
  input  logic          re,
  input  logic [AW-1:0] addr,
  output logic          rvalid_o
);

  logic [DEPTH-1:0] vbits;

  for (genvar g = 0; g < DEPTH; g++) begin : g_vb
    always_ff @(posedge clk) begin
      if (rst) vbits[g] <= 1'b0;
      else if (addr == AW'(g)) begin
        if (set)      vbits[g] <= 1'b1;
        else if (clr) vbits[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid_o <= 1'b0;
    else     rvalid_o <= re && vbits[addr];
  end

  AST_FILL_MARKS: assert property (@(posedge clk) disable iff (rst)
    set |=> vbits[$past(addr)]); // R2
  AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !vbits[$past(addr)]); // R7
  AST_RESET_EMPTY: assert property (@(posedge clk)
    rst |=> (vbits == '0) && !rvalid_o); // R6

endmodule

// File: rtl/wt_way_tag_array.sv
module wt_way_tag_array
  import wt_pkg::*;
#(
  parameter int L1_BYTES      = 4096,
  parameter int L1_LINE_BYTES = 32,
  parameter int L1_WAYS       = 4,
  parameter int L2_WAYS       = 4,
  localparam int ENTRIES = L1_BYTES / L1_LINE_BYTES,
  localparam int SETS    = ENTRIES / L1_WAYS,
  localparam int SET_W   = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int L1W_W   = (L1_WAYS > 1) ? $clog2(L1_WAYS) : 1,
  localparam int CODE_W  = code_width(L2_WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SET_W-1:0]  idx_i,
  input  logic [L1W_W-1:0]  l1way_i,
  input  logic              upd_i,
  input  logic              wr_i,
  input  logic              inval_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o
);

  localparam int AW = SET_W + L1W_W;

  logic [AW-1:0] addr;
  wt_op_e        op;
  wt_ctl_t       ctl;

  assign addr = {l1way_i, idx_i};

  wt_ctrl u_ctrl (
    .upd_i   (upd_i),
    .wr_i    (wr_i),
    .inval_i (inval_i),
    .op_o    (op),
    .ctl_o   (ctl)
  );

  wt_code_ram #(.DEPTH(1 << AW), .AW(AW), .DW(CODE_W)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (ctl.ram_we),
    .re    (ctl.ram_re),
    .addr  (addr),
    .wdata (code_i),
    .rdata (code_o)
  );

  wt_valid_bits #(.DEPTH(1 << AW), .AW(AW)) u_vb (
    .clk      (clk),
    .rst      (rst),
    .set      (ctl.vb_set),
    .clr      (ctl.vb_clr),
    .re       (ctl.ram_re),
    .addr     (addr),
    .rvalid_o (valid_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> !valid_o && $stable(code_o)); // R5
  AST_FILL_SILENT: assert property (@(posedge clk) disable iff (rst)
    (upd_i && wr_i) |=> !valid_o && $stable(code_o)); // R10

endmodule

// File: tb/sim_wt_way_tag_array.sv
module sim_wt_way_tag_array;

  localparam int SETS = 32;
  localparam int WAYS = 4;
  localparam int ENT  = SETS * WAYS;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] idx_i = '0;
  logic [1:0] l1way_i = '0;
  logic       upd_i = 1'b0, wr_i = 1'b0, inval_i = 1'b0;
  logic [1:0] code_i = '0;
  logic [1:0] code_o;
  logic       valid_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  bit [1:0] m_code [ENT];
  bit       m_vld  [ENT];
  bit       m_wrt  [ENT];
  bit [1:0] e_code = 2'd0;
  bit       e_known = 1'b1;

  always #10 clk = ~clk;

  wt_way_tag_array u0 (
    .clk(clk), .rst(rst), .idx_i(idx_i), .l1way_i(l1way_i),
    .upd_i(upd_i), .wr_i(wr_i), .inval_i(inval_i), .code_i(code_i),
    .code_o(code_o), .valid_o(valid_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int addr_of(input int set, input int way);
    return way * SETS + set;
  endfunction

  task automatic do_reset();
    rst = 1'b1; upd_i = 0; wr_i = 0; inval_i = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < ENT; i++) m_vld[i] = 1'b0;
    e_code = 2'd0; e_known = 1'b1;
    chk(valid_o == 1'b0, "R6 valid_o after reset", valid_o, 0);
    chk(code_o == 2'd0, "R6 code_o after reset", code_o, 0);
  endtask

  // one access, driven at a negedge and checked at the following negedge
  task automatic step(input bit upd, input bit wr, input bit inv,
                      input int set, input int way, input bit [1:0] c,
                      input string tag);
    int a;
    bit e_v;
    a = addr_of(set, way);
    upd_i = upd; wr_i = wr; inval_i = inv;
    idx_i = 5'(set); l1way_i = 2'(way); code_i = c;
    e_v = 1'b0;
    if (wr && !upd) begin
      e_v = m_vld[a];
      e_known = m_wrt[a];
      e_code = m_code[a];
    end
    if (wr && upd) begin
      m_code[a] = c; m_vld[a] = 1'b1; m_wrt[a] = 1'b1;
    end else if (inv) begin
      m_vld[a] = 1'b0;
    end
    @(negedge clk);
    upd_i = 0; wr_i = 0; inval_i = 0;
    chk(valid_o == e_v, {tag, " valid_o"}, valid_o, e_v);
    if (e_known) chk(code_o == e_code, {tag, " code_o"}, code_o, e_code);
  endtask

  initial begin
    int seed;
    seed = $urandom(1234);
    for (int i = 0; i < ENT; i++) begin
      m_code[i] = '0; m_vld[i] = 1'b0; m_wrt[i] = 1'b0;
    end
    @(negedge clk);
    do_reset();
    step(0, 1, 0, 3, 0, 0, "R6 lookup after reset");
    step(0, 1, 0, 31, 3, 0, "R4 lookup empty");
    // R1 R9: four L1 ways of one set hold distinct codes
    step(1, 1, 0, 3, 0, 2'd2, "R2 fill");
    step(1, 1, 0, 3, 1, 2'd0, "R2 fill");
    step(1, 1, 0, 3, 2, 2'd3, "R2 fill");
    step(1, 1, 0, 3, 3, 2'd1, "R2 fill");
    for (int w = 0; w < 4; w++) step(0, 1, 0, 3, w, 0, "R1 R9 lookup");
    step(0, 1, 0, 4, 0, 0, "R1 neighbour set empty");
    // R5: update without write strobe stores nothing
    step(1, 0, 0, 3, 0, 2'd3, "R5 upd alone");
    step(0, 0, 0, 3, 0, 0, "R5 idle");
    step(0, 1, 0, 3, 0, 0, "R5 code unchanged");
    // R7: lookup with invalidate returns prior state
    step(0, 1, 1, 3, 1, 0, "R7 lookup+inval");
    step(0, 1, 0, 3, 1, 0, "R7 after inval");
    // R8: fill wins over invalidate
    step(1, 1, 1, 3, 2, 2'd1, "R8 fill+inval");
    step(0, 1, 0, 3, 2, 0, "R8 lookup");
    // R10: fill then immediate lookup
    step(1, 1, 0, 7, 2, 2'd3, "R10 fill no response");
    step(0, 1, 0, 7, 2, 0, "R10 lookup");
    // random mix on a few sets
    for (int k = 0; k < 4000; k++) begin
      int r, s, w;
      bit [1:0] c;
      r = $urandom_range(0, 9);
      s = $urandom_range(0, 3) * 9;
      w = $urandom_range(0, 3);
      c = 2'($urandom_range(0, 3));
      if (k == 2000) do_reset();
      if (r < 3)      step(1, 1, ($urandom_range(0, 3) == 0), s, w, c, "R2 R8 rnd fill");
      else if (r < 7) step(0, 1, ($urandom_range(0, 4) == 0), s, w, c, "R3 R4 R7 rnd lookup");
      else if (r < 8) step(0, 0, 1, s, w, c, "R7 rnd inval");
      else            step($urandom_range(0, 1) == 1, 0, 0, s, w, c, "R5 rnd idle");
    end
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule